// File: doc/BRIEF.md
# Instant Edge Reset Merger

This block turns an active-high "reset now" input into a reset pulse of fixed length, starting as soon as the input's rising edge has passed through a two-flop synchronizer. The input needs no hold time. A pulse as short as one clock cycle still produces the full pulse.

After a pulse has been accepted, the falling edge of the same input opens a debounce window. Rising edges inside that window are dropped. The window is not restarted by input activity inside it, and once it expires the next rising edge is accepted normally.

The block also takes a request from a separate long-press timer, which lives elsewhere and already applies its own setup-time filtering. That request fires a second pulse timer of its own. Both timers drive one shared active-low reset line, which stays low while either timer is running. All durations are counted in ticks of an external timebase strobe, so one clock domain can cover anything from microseconds to seconds.

Top module: `instant_reset_merge`

## Requirements
- R1: Once `rst_n` is released and no request has arrived, `rst_out_n` reads 1.
- R2: With the default two synchronizer stages and a registered output, suppose `inst_req_i` goes high before clock edge k and is accepted. Then `rst_out_n` is still 1 after edge k+2 and reads 0 after edge k+3.
- R3: An accepted instant edge loads a pulse of `PULSE_TICKS` ticks. When `tick` is high every cycle, `rst_out_n` stays 0 for exactly `PULSE_TICKS` clock cycles.
- R4: There is no hold-time requirement. An `inst_req_i` high for a single clock cycle still produces the full pulse of R3.
- R5: A falling edge of the synchronized instant input that follows an accepted rising edge starts a debounce window of `DEB_TICKS` ticks. A rising edge that arrives while the window is running produces no output response.
- R6: A falling edge that arrives while the instant pulse is still running also starts the window, and the window keeps running after the pulse has ended.
- R7: A rising edge that arrives after the window has expired is accepted and starts a new pulse.
- R8: A 0-to-1 transition of `lp_req_i` (sampled before edge j) drives `rst_out_n` to 0 after edge j+1. The output then stays 0 for `PULSE_TICKS` ticks, on a timer separate from the instant path.
- R9: While either pulse timer is running, `rst_out_n` is 0. When both pulses overlap, the output returns to 1 only after the later of the two pulses has ended.
- R10: A rising edge that was ignored does not arm the debounce logic. Its later falling edge neither starts nor restarts a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; one tick is counted per cycle it is high |
| inst_req_i | input | 1 | Asynchronous active-high instant reset request |
| lp_req_i | input | 1 | Synchronous long-press request; a rising edge starts a pulse |
| rst_out_n | output | 1 | Merged active-low reset output |

## Verification
The bench targets four window boundaries:
- A rising edge landing during the last tick of the debounce window. A design that compares against the wrong counter value would accept it one tick early or late.
- A falling edge while the pulse is still high. A design that opens the window only after the pulse would let a quick re-press through.
- The falling edge of an ignored press. A design that re-arms on any edge would restart the window and swallow a legitimate later press.
- Overlapping long-press and instant pulses. A design that ORs the pulses incorrectly, or shares one timer between them, would release the line when the earlier pulse ends.

Random phases with a sparse tick then test all of these edges against a cycle model built from the requirements.

// File: rtl/irc_pkg.sv
package irc_pkg;

   // Width of a down-counter that must hold the value n.
   function automatic int cnt_width(input int n);
      int w;
      w = $clog2(n + 1);
      if (w < 1) w = 1;
      return w;
   endfunction

   // Edge flags taken from a synchronized level.
   typedef struct packed {
      logic rise;
      logic fall;
   } irc_edge_t;

endpackage

// File: rtl/irc_sync_edge.sv
module irc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_async,
   output logic              level,
   output irc_pkg::irc_edge_t edges
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
         prev  <= chain[STAGES-1];
      end
   end

   assign level      = chain[STAGES-1];
   assign edges.rise = chain[STAGES-1] & ~prev;
   assign edges.fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/irc_tick_timer.sv
module irc_tick_timer #(
   parameter int TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   output logic busy
);

   localparam int            CW    = irc_pkg::cnt_width(TICKS);
   localparam logic [CW-1:0] LOADV = CW'(TICKS);

   if (TICKS < 1) begin : g_bad_ticks
      $error("irc_tick_timer: TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= LOADV;
      end else if (tick && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

   // R3: a load always leaves the timer running on the next cycle
   p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

   // R3: the count never leaves its legal range
   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOADV);

   // R3: without a tick or load the count holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/irc_edge_gate.sv
module irc_edge_gate (
   input  logic               clk,
   input  logic               rst_n,
   input  irc_pkg::irc_edge_t edges,
   input  logic               win_busy,
   output logic               accept,
   output logic               win_start,
   output logic               armed_o
);

   logic armed;

   assign accept    = edges.rise & ~win_busy;
   assign win_start = edges.fall & armed;
   assign armed_o   = armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (accept) begin
         armed <= 1'b1;
      end else if (win_start) begin
         armed <= 1'b0;
      end
   end

   // R5: an accepted edge arms the window logic
   p_accept_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> armed);

   // R10: opening the window consumes the arm
   p_start_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |=> !armed);

endmodule

// File: rtl/instant_reset_merge.sv
module instant_reset_merge #(
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_TICKS = 8,
   parameter int DEB_TICKS   = 12,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic inst_req_i,
   input  logic lp_req_i,
   output logic rst_out_n
);

   if (PULSE_TICKS < 1 || DEB_TICKS < 1) begin : g_bad_timing
      $error("instant_reset_merge: tick counts must be at least 1");
   end

   irc_pkg::irc_edge_t inst_edges;
   logic inst_level;
   logic accept, win_start, armed;
   logic inst_busy, win_busy, lp_busy;
   logic lp_prev, lp_rise;
   logic any_busy;

   irc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (inst_req_i),
      .level   (inst_level),
      .edges   (inst_edges)
   );

   irc_edge_gate i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .edges     (inst_edges),
      .win_busy  (win_busy),
      .accept    (accept),
      .win_start (win_start),
      .armed_o   (armed)
   );

   irc_tick_timer #(.TICKS(PULSE_TICKS)) i_inst_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (accept),
      .busy  (inst_busy)
   );

   irc_tick_timer #(.TICKS(DEB_TICKS)) i_window (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (win_start),
      .busy  (win_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_prev <= 1'b0;
      else        lp_prev <= lp_req_i;
   end

   assign lp_rise = lp_req_i & ~lp_prev;

   irc_tick_timer #(.TICKS(PULSE_TICKS)) i_lp_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (lp_rise),
      .busy  (lp_busy)
   );

   assign any_busy = inst_busy | lp_busy;

   if (OUT_REG) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b1;
         else        out_q <= ~any_busy;
      end
      assign rst_out_n = out_q;

      // R1: with both timers idle the line is released
      p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (!inst_busy && !lp_busy) |=> rst_out_n);

      // R9: either running timer holds the line low
      p_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (inst_busy || lp_busy) |=> !rst_out_n);
   end else begin : g_out_comb
      assign rst_out_n = ~any_busy;
   end

   // R5: a rising edge inside the window does not start a pulse
   p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_edges.rise && win_busy && !inst_busy) |=> !inst_busy);

   // R6: a falling edge after an accepted press opens the window
   p_fall_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_edges.fall && armed) |=> win_busy);

   // R10: an unarmed falling edge leaves an idle window idle
   p_no_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_edges.fall && !armed && !win_busy) |=> !win_busy);

   // R8: the long-press edge starts its own timer
   p_lp_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lp_rise |=> lp_busy);

   // R2: the synchronized level only moves through an edge flag
   p_level_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inst_level) |-> inst_edges.rise);

endmodule

// File: tb/test_instant_reset_merge.sv
module test_instant_reset_merge;

   localparam int P = 8;
   localparam int D = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic inst_req_i = 1'b0;
   logic lp_req_i = 1'b0;
   logic rst_out_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   instant_reset_merge #(
      .SYNC_STAGES (2),
      .PULSE_TICKS (P),
      .DEB_TICKS   (D),
      .OUT_REG     (1'b1)
   ) i_instant_reset_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .inst_req_i (inst_req_i),
      .lp_req_i   (lp_req_i),
      .rst_out_n  (rst_out_n)
   );

   // Cycle model derived from the requirements.
   logic m_s1, m_s2, m_prev, m_armed, m_lpprev, m_out;
   int   m_ci, m_cw, m_cl;

   function automatic int next_cnt(input bit ld, input int ldv, input bit tk, input int c);
      if (ld) return ldv;
      if (tk && c != 0) return c - 1;
      return c;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_armed <= 0; m_lpprev <= 0;
         m_out <= 1; m_ci <= 0; m_cw <= 0; m_cl <= 0;
      end else begin
         bit rise, fall, acc, ws, lr;
         rise = m_s2 && !m_prev;
         fall = !m_s2 && m_prev;
         acc  = rise && (m_cw == 0);
         ws   = fall && m_armed;
         lr   = lp_req_i && !m_lpprev;
         m_s1 <= inst_req_i;
         m_s2 <= m_s1;
         m_prev <= m_s2;
         m_lpprev <= lp_req_i;
         m_ci <= next_cnt(acc, P, tick, m_ci);
         m_cw <= next_cnt(ws, D, tick, m_cw);
         m_cl <= next_cnt(lr, P, tick, m_cl);
         m_armed <= acc ? 1'b1 : (ws ? 1'b0 : m_armed);
         m_out <= !((m_ci != 0) || (m_cl != 0));
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rst_out_n actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // Cycle-by-cycle comparison with the model (R9 merge, covers all timing).
   always @(negedge clk) begin
      if (rst_n && !done) chk("R9 model", rst_out_n, m_out);
   end

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         finish_run();
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      step(5);
      rst_n = 1'b1;
      step(1);
      chk("R1", rst_out_n, 1'b1);

      // Single-cycle press: latency, length, no hold time.
      inst_req_i = 1'b1; step(1);
      inst_req_i = 1'b0; step(2);
      chk("R2 early", rst_out_n, 1'b1);
      step(1);
      chk("R2", rst_out_n, 1'b0);
      step(7);
      chk("R3 last low", rst_out_n, 1'b0);
      step(1);
      chk("R4 full pulse", rst_out_n, 1'b1);

      // Press inside the window is ignored.
      inst_req_i = 1'b1; step(1);
      inst_req_i = 1'b0; step(5);
      chk("R5", rst_out_n, 1'b1);

      // Window expired, ignored fall did not restart it.
      inst_req_i = 1'b1; step(1);
      inst_req_i = 1'b0; step(3);
      chk("R10", rst_out_n, 1'b0);
      step(1);
      chk("R7", rst_out_n, 1'b0);

      // Fall during the pulse: window outlives the pulse.
      step(7);
      chk("R3 end", rst_out_n, 1'b1);
      inst_req_i = 1'b1; step(1);
      inst_req_i = 1'b0; step(5);
      chk("R6", rst_out_n, 1'b1);
      step(20);

      // Long-press path.
      lp_req_i = 1'b1; step(1);
      chk("R8 early", rst_out_n, 1'b1);
      lp_req_i = 1'b0; step(1);
      chk("R8", rst_out_n, 1'b0);
      step(7);
      chk("R8 last low", rst_out_n, 1'b0);
      step(1);
      chk("R8 end", rst_out_n, 1'b1);
      step(5);

      // Overlap: later pulse decides release.
      lp_req_i = 1'b1; step(1);
      lp_req_i = 1'b0; step(3);
      inst_req_i = 1'b1; step(1);
      inst_req_i = 1'b0; step(10);
      chk("R9 overlap low", rst_out_n, 1'b0);
      step(1);
      chk("R9 overlap end", rst_out_n, 1'b1);
      step(30);

      // Random phase with sparse ticks, checked by the model.
      for (int i = 0; i < 6000; i++) begin
         tick = ($urandom % 3) == 0;
         if (($urandom % 7) == 0) inst_req_i = ~inst_req_i;
         lp_req_i = ($urandom % 60) == 0;
         step(1);
      end
      tick = 1'b1;
      inst_req_i = 1'b0;
      lp_req_i = 1'b0;
      step(60);
      chk("R1 idle again", rst_out_n, 1'b1);
      finish_run();
   end

endmodule